// File: doc/BRIEF.md
# Selectable-Divider SPI Serial Clock Generator

This block turns a fast source clock into the serial clock of an SPI shifter, together with single-cycle strobes that mark every SCLK edge. Two divider paths are available. The linear path divides the source by twice (value + 1), using an 8-bit value. The power-of-two path divides the source by four times two to the power of a 3-bit exponent. A select input picks the linear path when high and the power-of-two path when low.

The shifter holds `run` high for the length of a burst. While `run` is low the generator is idle: SCLK rests at the clock-polarity level and it captures the divider settings on every cycle. The settings seen in the cycle where `run` is first sampled high are the ones used for the whole burst, so a change of path or divisor never cuts a pulse short. The divider counter restarts at the start of each burst, so the first SCLK half period has full length.

Each SCLK period produces one leading-edge strobe and one trailing-edge strobe. The clock-phase setting maps these strobes onto sample and shift strobes for the shifter.

Top module: `spi_clkgen`

## Requirements
- R1: While reset is asserted, `sclk`, `leadStb`, `trailStb`, `sampleStb` and `shiftStb` are all low.
- R2: In a cycle after a clock edge at which `run` was low, `sclk` equals the `cpol` value sampled at that edge, and no strobe is high.
- R3: With `linSel` low, each SCLK half period lasts 2^(`powExp`+1) source cycles, which is a full period of 4·2^`powExp` (codes 0,1,2,3 give 4,8,16,32).
- R4: With `linSel` high, each SCLK half period lasts `linDiv`+1 source cycles, which is a full period of 2·(`linDiv`+1). A value of 0 toggles SCLK on every source cycle.
- R5: The same `powExp` and `linDiv` values give the power-of-two timing when `linSel` is 0 and the linear timing when `linSel` is 1.
- R6: `linSel`, `powExp`, `linDiv` and `cpha` are captured at the edge where `run` is first sampled high. Changes to them (and to `cpol`) while `run` stays high have no effect on `sclk` or on the strobes until the burst ends.
- R7: The first SCLK transition of a burst comes exactly one full half period after the edge where `run` is first sampled high.
- R8: `leadStb` is high for one cycle, together with each transition of SCLK away from its idle level. `trailStb` is high for one cycle with each transition back to it. The two are never high together.
- R9: With `cpha` = 0, `sampleStb` follows `leadStb` and `shiftStb` follows `trailStb`. With `cpha` = 1 the mapping is swapped.
- R10: When `run` falls, even in the middle of a half period, `sclk` returns to `cpol` at the next edge and the next burst starts from a fresh half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous reset, active low |
| run | input | 1 | High for the duration of a burst |
| linSel | input | 1 | 1 selects the linear path, 0 the power-of-two path |
| powExp | input | EXP_W | Exponent of the power-of-two path |
| linDiv | input | LIN_W | Divisor value of the linear path |
| cpol | input | 1 | Idle level of SCLK |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| sclk | output | 1 | Serial clock level |
| leadStb | output | 1 | One-cycle strobe on each leading SCLK edge |
| trailStb | output | 1 | One-cycle strobe on each trailing SCLK edge |
| sampleStb | output | 1 | Strobe telling the shifter to sample |
| shiftStb | output | 1 | Strobe telling the shifter to drive the next bit |

## Verification
The bench builds the generator with its default widths: a 3-bit exponent and an 8-bit linear divisor. With these widths both extremes of the counter are in reach within a few hundred cycles. The exponent 7 gives 256-cycle half periods on the power-of-two path. The linear value 255 gives the same half period on the other path, and the value 0 toggles SCLK every cycle. The stimulus covers both polarities, both phases, a burst whose settings are disturbed half-way through, and a burst cut off in the middle of a half period.

// File: rtl/spi_clkgen_pkg.sv
package spi_clkgen_pkg;

  // Strobes from the control FSM to the divider datapath
  typedef struct packed {
    logic load;   // capture divider settings (generator idle)
    logic clear;  // hold the half-period counter at zero
    logic count;  // advance the half-period counter
  } cnt_ctl_t;

endpackage

// File: rtl/spi_clkgen_dp.sv
module spi_clkgen_dp
  import spi_clkgen_pkg::*;
#(
  parameter int EXP_W  = 3,
  parameter int LIN_W  = 8,
  parameter int TERM_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_ctl_t         ctl,
  input  logic             linSel,
  input  logic [EXP_W-1:0] powExp,
  input  logic [LIN_W-1:0] linDiv,
  input  logic             cphaIn,
  output logic             termHit,
  output logic             cphaQ
);

  logic [TERM_W-1:0] powTerm;
  logic [TERM_W-1:0] linTerm;
  logic [TERM_W-1:0] nextTerm;
  logic [TERM_W-1:0] termQ;
  logic [TERM_W-1:0] cnt;

  // Power-of-two half period minus one: a mask of (powExp + 1) ones
  for (genvar i = 0; i < TERM_W; i++) begin : g_powMask
    assign powTerm[i] = (32'(powExp) >= i);
  end

  // Linear half period minus one is the programmed value itself
  assign linTerm  = TERM_W'(linDiv);
  assign nextTerm = linSel ? linTerm : powTerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      termQ <= '0;
      cphaQ <= 1'b0;
    end else if (ctl.load) begin
      termQ <= nextTerm;
      cphaQ <= cphaIn;
    end
  end

  assign termHit = (cnt == termQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.clear) begin
      cnt <= '0;
    end else if (ctl.count) begin
      cnt <= termHit ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_clkgen_ctl.sv
module spi_clkgen_ctl
  import spi_clkgen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     run,
  input  logic     cpolIn,
  input  logic     termHit,
  input  logic     cphaQ,
  output cnt_ctl_t ctl,
  output logic     sclk,
  output logic     leadStb,
  output logic     trailStb,
  output logic     sampleStb,
  output logic     shiftStb
);

  logic active;
  logic phase;   // 0: next edge leaves idle level, 1: next edge returns
  logic edgeNow;

  assign ctl.load  = !active;
  assign ctl.clear = !(active && run);
  assign ctl.count = active && run;
  assign edgeNow   = active && run && termHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      phase    <= 1'b0;
      sclk     <= 1'b0;
      leadStb  <= 1'b0;
      trailStb <= 1'b0;
    end else begin
      leadStb  <= edgeNow && !phase;
      trailStb <= edgeNow && phase;
      if (!active) begin
        active <= run;
        phase  <= 1'b0;
        sclk   <= cpolIn;
      end else if (!run) begin
        active <= 1'b0;
        phase  <= 1'b0;
        sclk   <= cpolIn;
      end else if (termHit) begin
        phase <= !phase;
        sclk  <= !sclk;
      end
    end
  end

  assign sampleStb = cphaQ ? trailStb : leadStb;
  assign shiftStb  = cphaQ ? leadStb  : trailStb;

endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
  import spi_clkgen_pkg::*;
#(
  parameter int EXP_W = 3,
  parameter int LIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             linSel,
  input  logic [EXP_W-1:0] powExp,
  input  logic [LIN_W-1:0] linDiv,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sclk,
  output logic             leadStb,
  output logic             trailStb,
  output logic             sampleStb,
  output logic             shiftStb
);

  localparam int POW_TERM_W = 1 << EXP_W;
  localparam int TERM_W     = (POW_TERM_W > LIN_W) ? POW_TERM_W : LIN_W;

  cnt_ctl_t ctl;
  logic     termHit;
  logic     cphaQ;

  spi_clkgen_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .run      (run),
    .cpolIn   (cpol),
    .termHit  (termHit),
    .cphaQ    (cphaQ),
    .ctl      (ctl),
    .sclk     (sclk),
    .leadStb  (leadStb),
    .trailStb (trailStb),
    .sampleStb(sampleStb),
    .shiftStb (shiftStb)
  );

  spi_clkgen_dp #(
    .EXP_W (EXP_W),
    .LIN_W (LIN_W),
    .TERM_W(TERM_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .linSel (linSel),
    .powExp (powExp),
    .linDiv (linDiv),
    .cphaIn (cpha),
    .termHit(termHit),
    .cphaQ  (cphaQ)
  );

endmodule

// File: rtl/spi_clkgen_chk.sv
module spi_clkgen_chk (
  input logic clk,
  input logic rstN,
  input logic run,
  input logic cpol,
  input logic sclk,
  input logic leadStb,
  input logic trailStb,
  input logic sampleStb,
  input logic shiftStb
);

  logic pastOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !$past(run)) |-> (sclk == $past(cpol) && !leadStb && !trailStb));

  // R8
  lead_trail_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(leadStb && trailStb));

  // R8
  lead_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    leadStb |=> !leadStb);

  // R8
  strobe_on_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && (leadStb || trailStb)) |-> (sclk != $past(sclk)));

  // R9
  sample_shift_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sampleStb, shiftStb}) &&
    ($countones({sampleStb, shiftStb}) == $countones({leadStb, trailStb})));

endmodule

bind spi_clkgen spi_clkgen_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .run      (run),
  .cpol     (cpol),
  .sclk     (sclk),
  .leadStb  (leadStb),
  .trailStb (trailStb),
  .sampleStb(sampleStb),
  .shiftStb (shiftStb)
);

// File: tb/spi_clkgen_tb.sv
module spi_clkgen_tb;

  localparam int EXP_W = 3;
  localparam int LIN_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rstN = 1'b0;
  logic             run = 1'b0;
  logic             linSel = 1'b0;
  logic [EXP_W-1:0] powExp = '0;
  logic [LIN_W-1:0] linDiv = '0;
  logic             cpol = 1'b0;
  logic             cpha = 1'b0;
  logic sclk, leadStb, trailStb, sampleStb, shiftStb;

  spi_clkgen #(.EXP_W(EXP_W), .LIN_W(LIN_W)) u_dut (
    .clk(clk), .rstN(rstN), .run(run), .linSel(linSel), .powExp(powExp),
    .linDiv(linDiv), .cpol(cpol), .cpha(cpha), .sclk(sclk), .leadStb(leadStb),
    .trailStb(trailStb), .sampleStb(sampleStb), .shiftStb(shiftStb)
  );

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    cmpOn = 0;
  bit    done = 0;

  // Behavioural reference: elapsed cycles in the current half period
  bit mAct, mSclk, mLead, mTrail, mUp, mCpha;
  int mElapsed, mHalf;

  always @(posedge clk) begin
    #1;
    mLead = 0;
    mTrail = 0;
    if (!rstN) begin
      mAct = 0; mSclk = 0; mUp = 0; mElapsed = 0; mCpha = 0; mHalf = 1;
    end else if (!mAct) begin
      mHalf    = linSel ? (int'(linDiv) + 1) : (1 << (int'(powExp) + 1));
      mCpha    = cpha;
      mSclk    = cpol;
      mElapsed = 0;
      mUp      = 0;
      mAct     = run;
    end else if (!run) begin
      mAct = 0; mSclk = cpol; mElapsed = 0; mUp = 0;
    end else begin
      mElapsed++;
      if (mElapsed == mHalf) begin
        mElapsed = 0;
        mSclk = !mSclk;
        if (!mUp) mLead = 1; else mTrail = 1;
        mUp = !mUp;
      end
    end
  end

  always @(negedge clk) begin
    if (cmpOn && !done) begin
      bit eSample, eShift;
      eSample = mCpha ? mTrail : mLead;
      eShift  = mCpha ? mLead : mTrail;
      checks++;
      if ({sclk, leadStb, trailStb, sampleStb, shiftStb} !==
          {mSclk, mLead, mTrail, eSample, eShift}) begin
        errors++;
        $display("FAIL %s: sclk/lead/trail/sample/shift actual %b%b%b%b%b expected %b%b%b%b%b at %0t",
                 curReq, sclk, leadStb, trailStb, sampleStb, shiftStb,
                 mSclk, mLead, mTrail, eSample, eShift, $time);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called just after a negedge; returns just after a negedge.
  task automatic runBurst(input bit ls, input int e, input int l, input bit cp,
                          input bit ch, input int cycles, input string req,
                          input bit mutate);
    int  half, leads, trails, nTog;
    bit  seen;
    curReq = req;
    linSel = ls; powExp = EXP_W'(e); linDiv = LIN_W'(l); cpol = cp; cpha = ch;
    run = 1;
    half = ls ? (l + 1) : (1 << (e + 1));
    seen = 0; leads = 0; trails = 0;
    for (int i = 1; i <= cycles; i++) begin
      @(negedge clk);
      if (!seen && (sclk !== cp)) begin
        seen = 1;
        // R7: first transition one half period after run is first seen
        chk(i == half + 1, "R7", "negedge index of first sclk transition", i, half + 1);
      end
      leads  += int'(leadStb);
      trails += int'(trailStb);
      if (mutate && i == cycles / 2) begin
        curReq = "R6";
        linSel = !ls; powExp = ~powExp; linDiv = ~linDiv; cpol = !cp; cpha = !ch;
      end
    end
    nTog = (cycles - 1) / half;
    chk(leads == (nTog + 1) / 2, "R8", "leading strobe count", leads, (nTog + 1) / 2);
    chk(trails == nTog / 2, "R8", "trailing strobe count", trails, nTog / 2);
    run = 0;
    curReq = "R10";
    @(negedge clk);
    chk(sclk === cpol, "R10", "sclk after run fall", int'(sclk), int'(cpol));
    chk(!leadStb && !trailStb, "R10", "strobes after run fall",
        int'({leadStb, trailStb}), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk({sclk, leadStb, trailStb, sampleStb, shiftStb} === 5'b0, "R1",
          "outputs in reset", int'({sclk, leadStb, trailStb, sampleStb, shiftStb}), 0);
    end
    rstN = 1;
    cmpOn = 1;
    curReq = "R2";
    repeat (3) @(negedge clk);
    chk(sclk === 1'b0, "R2", "idle sclk with cpol 0", int'(sclk), 0);
    cpol = 1;
    repeat (3) @(negedge clk);
    chk(sclk === 1'b1, "R2", "idle sclk with cpol 1", int'(sclk), 1);
    cpol = 0;
    repeat (2) @(negedge clk);

    runBurst(0, 0, 0, 0, 0, 40, "R3", 0);
    runBurst(0, 2, 0, 1, 1, 70, "R9", 0);
    runBurst(0, 7, 0, 0, 0, 600, "R3", 0);
    runBurst(1, 0, 0, 0, 1, 20, "R4", 0);
    runBurst(1, 0, 4, 1, 0, 45, "R4", 0);
    runBurst(1, 0, 255, 0, 0, 600, "R4", 0);
    runBurst(0, 1, 2, 0, 0, 30, "R5", 0);
    runBurst(1, 1, 2, 0, 0, 30, "R5", 0);
    runBurst(1, 0, 3, 0, 0, 60, "R6", 1);
    runBurst(0, 1, 0, 0, 0, 6, "R10", 0);
    runBurst(0, 1, 0, 1, 1, 20, "R10", 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule